// File: doc/BRIEF.md
# Bank-Address and Write-Data Separator for a Time-Multiplexed Processor Bus

This block sits beside a processor whose eight shared data lines carry
address bits 16 to 23 while the phase-2 clock is low and the data byte while
it is high. It watches those lines, the sixteen low address lines, the
read/write pin, the bus-enable input and a status pin that carries two flags
on opposite phase-2 edges. From them it produces a full 24-bit address, a
write byte with a one-clock valid strobe, and separate M and X flags.

All processor-side inputs are sampled in the fabric clock domain. They pass
through one common delay line of `SYNC_STAGES` flops, so the phase-2 edges
and the values that surround them stay aligned. The same line is the
two-flop synchronizer for the asynchronous bus-enable input. Each phase-2
half must last at least `SYNC_STAGES + 2` fabric clocks.

Top module: `mdx_bank_demux`

## Requirements
- R1: While `rst` is high, every output goes to its idle value on the next clock: `addr_o` = 0, `wdata_o` = 0, `wvalid_o` = 0, `m_o` = 1 and `x_o` = 1.
- R2: In the low half of phase 2, with bus-enable high, `addr_o` equals `{mbus_i, alo_i}`, with the bank byte in bits 23..16. It shows the low-half values by the end of that half.
- R3: `addr_o` does not change during the high half of phase 2, even when the shared lines switch to data.
- R4: For each bus cycle with `rw_i` = 0 (write) and bus-enable high for the whole cycle, `wvalid_o` pulses high for exactly one clock after the next falling edge of phase 2. `wdata_o` then holds the byte that was on the shared lines at the end of the high half.
- R5: A cycle with `rw_i` = 1 (read) produces no `wvalid_o` pulse and leaves `wdata_o` unchanged.
- R6: If bus-enable is low at any sample of a cycle, that cycle produces no strobe. While bus-enable is low, `addr_o` keeps its previous value.
- R7: After each falling edge of phase 2, `m_o` takes the level the status pin had at the end of the high half. Bus-enable does not affect it.
- R8: After each rising edge of phase 2, `x_o` takes the level the status pin had at the end of the low half. Bus-enable does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phi2_i | input | 1 | Processor phase-2 clock, used here as data |
| alo_i | input | LO_W | Low address lines from the processor |
| mbus_i | input | BANK_W | Shared lines: bank byte in the low half, data in the high half |
| rw_i | input | 1 | Read/write from the processor, 1 = read |
| be_i | input | 1 | Bus-enable, asynchronous; low means the processor bus floats |
| mx_i | input | 1 | Status pin carrying M at the falling edge and X at the rising edge |
| addr_o | output | LO_W+BANK_W | Assembled full address |
| wdata_o | output | BANK_W | Last captured write byte |
| wvalid_o | output | 1 | One-clock strobe marking a new `wdata_o` |
| m_o | output | 1 | Separated M flag |
| x_o | output | 1 | Separated X flag |

## Verification
The bench runs a series of bus cycles. Each cycle uses different low-address,
bank and data values, computed from the cycle index. The index bits also set
the cycle's read/write type, its bus-enable pattern (always high, low in the
address half, or low in the data half) and its M and X levels.

Writes with bus-enable high are told apart from reads and from both kinds of
gated cycle by counting strobes and following the write byte. Driving
different M and X levels on the one status pin in the two halves shows that
each flag is taken on its own edge. Checking the address at the end of the
data half shows that the data byte does not leak into the bank bits.

// File: rtl/mdx_pkg.sv
`timescale 1ns/1ps
package mdx_pkg;
  // Phase-2 transition seen in the fabric clock domain
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } phase_edge_e;
endpackage

// File: rtl/mdx_delay_line.sv
`timescale 1ns/1ps
module mdx_delay_line #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mdx_phase_tap.sv
`timescale 1ns/1ps
module mdx_phase_tap
  import mdx_pkg::*;
#(
  parameter int W       = 8,
  parameter int PHI_BIT = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output phase_edge_e  edge_kind
);
  // Keep the sample from one clock earlier. At an edge this is the last
  // sample that belonged to the half that just ended.
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end

  always_comb begin
    edge_kind = EDGE_NONE;
    if (cur[PHI_BIT] && !prev[PHI_BIT])      edge_kind = EDGE_RISE;
    else if (!cur[PHI_BIT] && prev[PHI_BIT]) edge_kind = EDGE_FALL;
  end
endmodule

// File: rtl/mdx_addr_capture.sv
`timescale 1ns/1ps
module mdx_addr_capture #(
  parameter int LO_W   = 16,
  parameter int BANK_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   phase_low,
  input  logic                   bus_enabled,
  input  logic [LO_W-1:0]        lo,
  input  logic [BANK_W-1:0]      bank,
  output logic [LO_W+BANK_W-1:0] addr
);
  // Follows the lines while phase 2 is low (transparent) and holds from
  // the rising edge on, so the address stays put through the data half.
  always_ff @(posedge clk) begin
    if (rst)                           addr <= '0;
    else if (phase_low && bus_enabled) addr <= {bank, lo};
  end
endmodule

// File: rtl/mdx_write_capture.sv
`timescale 1ns/1ps
module mdx_write_capture
  import mdx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_edge_e   edge_kind,
  input  logic          rw_prev,
  input  logic          be_cur,
  input  logic [DW-1:0] data_prev,
  output logic [DW-1:0] wdata,
  output logic          wvalid
);
  // cycle_ok is the AND of every bus-enable sample since the last fall.
  logic cycle_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_ok <= 1'b0;
      wvalid   <= 1'b0;
      wdata    <= '0;
    end else begin
      wvalid <= 1'b0;
      if (edge_kind == EDGE_FALL) begin
        cycle_ok <= be_cur;
        if (!rw_prev && cycle_ok) begin
          wvalid <= 1'b1;
          wdata  <= data_prev;
        end
      end else begin
        cycle_ok <= cycle_ok & be_cur;
      end
    end
  end
endmodule

// File: rtl/mdx_status_split.sv
`timescale 1ns/1ps
module mdx_status_split
  import mdx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  phase_edge_e edge_kind,
  input  logic        pin_prev,
  output logic        m_flag,
  output logic        x_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_flag <= 1'b1;
      x_flag <= 1'b1;
    end else begin
      unique case (edge_kind)
        EDGE_FALL: m_flag <= pin_prev;
        EDGE_RISE: x_flag <= pin_prev;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mdx_bank_demux.sv
`timescale 1ns/1ps
module mdx_bank_demux
  import mdx_pkg::*;
#(
  parameter int LO_W        = 16,
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   phi2_i,
  input  logic [LO_W-1:0]        alo_i,
  input  logic [BANK_W-1:0]      mbus_i,
  input  logic                   rw_i,
  input  logic                   be_i,
  input  logic                   mx_i,
  output logic [LO_W+BANK_W-1:0] addr_o,
  output logic [BANK_W-1:0]      wdata_o,
  output logic                   wvalid_o,
  output logic                   m_o,
  output logic                   x_o
);
  // Sample vector layout: {phi2, be, rw, mx, alo, bus}
  localparam int IN_W    = 4 + LO_W + BANK_W;
  localparam int ALO_LSB = BANK_W;
  localparam int MX_BIT  = BANK_W + LO_W;
  localparam int RW_BIT  = MX_BIT + 1;
  localparam int BE_BIT  = MX_BIT + 2;
  localparam int PHI_BIT = MX_BIT + 3;

  logic [IN_W-1:0] raw_vec;
  logic [IN_W-1:0] cur_vec;
  logic [IN_W-1:0] prev_vec;
  phase_edge_e     edge_kind;

  logic phi2_d;
  logic be_d;
  logic rw_q;

  assign raw_vec = {phi2_i, be_i, rw_i, mx_i, alo_i, mbus_i};

  // One common line: synchronizer for bus-enable, alignment for the rest
  mdx_delay_line #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_vec),
    .q   (cur_vec)
  );

  mdx_phase_tap #(.W(IN_W), .PHI_BIT(PHI_BIT)) u_tap (
    .clk       (clk),
    .rst       (rst),
    .cur       (cur_vec),
    .prev      (prev_vec),
    .edge_kind (edge_kind)
  );

  assign phi2_d = cur_vec[PHI_BIT];
  assign be_d   = cur_vec[BE_BIT];
  assign rw_q   = prev_vec[RW_BIT];

  mdx_addr_capture #(.LO_W(LO_W), .BANK_W(BANK_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .phase_low   (!phi2_d),
    .bus_enabled (be_d),
    .lo          (cur_vec[ALO_LSB +: LO_W]),
    .bank        (cur_vec[BANK_W-1:0]),
    .addr        (addr_o)
  );

  mdx_write_capture #(.DW(BANK_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .edge_kind (edge_kind),
    .rw_prev   (rw_q),
    .be_cur    (be_d),
    .data_prev (prev_vec[BANK_W-1:0]),
    .wdata     (wdata_o),
    .wvalid    (wvalid_o)
  );

  mdx_status_split u_stat (
    .clk       (clk),
    .rst       (rst),
    .edge_kind (edge_kind),
    .pin_prev  (prev_vec[MX_BIT]),
    .m_flag    (m_o),
    .x_flag    (x_o)
  );
endmodule

// File: rtl/mdx_demux_chk.sv
`timescale 1ns/1ps
module mdx_demux_chk
  import mdx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2_d,
  input logic              be_d,
  input logic              rw_q,
  input phase_edge_e       edge_kind,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DW-1:0]     wdata_o,
  input logic              wvalid_o,
  input logic              m_o,
  input logic              x_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && wdata_o == '0 && !wvalid_o && m_o && x_o));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phi2_d |=> $stable(addr_o));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid_o |=> !wvalid_o);

  // R4
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid_o |-> $past(edge_kind == EDGE_FALL));

  // R5
  strobe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid_o |-> $past(!rw_q));

  // R6
  be_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !be_d |=> $stable(addr_o));

  // R7
  m_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_o) |-> $past(edge_kind == EDGE_FALL));

  // R8
  x_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(x_o) |-> $past(edge_kind == EDGE_RISE));
endmodule

bind mdx_bank_demux mdx_demux_chk #(
  .ADDR_W (LO_W + BANK_W),
  .DW     (BANK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phi2_d    (phi2_d),
  .be_d      (be_d),
  .rw_q      (rw_q),
  .edge_kind (edge_kind),
  .addr_o    (addr_o),
  .wdata_o   (wdata_o),
  .wvalid_o  (wvalid_o),
  .m_o       (m_o),
  .x_o       (x_o)
);

// File: tb/mdx_bank_demux_tb.sv
`timescale 1ns/1ps
module mdx_bank_demux_tb;
  localparam int LO_W   = 16;
  localparam int BANK_W = 8;
  localparam int HALF   = 6;
  localparam int NCYC   = 48;

  logic clk = 1'b0;
  logic rst;
  logic phi2_i, rw_i, be_i, mx_i;
  logic [LO_W-1:0]        alo_i;
  logic [BANK_W-1:0]      mbus_i;
  logic [LO_W+BANK_W-1:0] addr_o;
  logic [BANK_W-1:0]      wdata_o;
  logic                   wvalid_o, m_o, x_o;

  int vectors = 0;
  int miscompares = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdx_bank_demux #(.LO_W(LO_W), .BANK_W(BANK_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .phi2_i(phi2_i), .alo_i(alo_i), .mbus_i(mbus_i),
    .rw_i(rw_i), .be_i(be_i), .mx_i(mx_i), .addr_o(addr_o),
    .wdata_o(wdata_o), .wvalid_o(wvalid_o), .m_o(m_o), .x_o(x_o)
  );

  always @(posedge clk) if (!rst && wvalid_o) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expectations carried from the previous bus cycle
  logic [LO_W+BANK_W-1:0] exp_addr  = '0;
  logic [BANK_W-1:0]      exp_wdata = '0;
  int                     exp_pulses = 0;
  logic                   exp_m = 1'b1;

  // be_mode: 0 = enabled all cycle, 1 = low in address half, 2 = low in data half
  task automatic bus_cycle(input logic [LO_W-1:0] lo, input logic [BANK_W-1:0] bank,
                           input logic [BANK_W-1:0] data, input logic rw,
                           input int be_mode, input logic mf, input logic xf);
    phi2_i = 1'b0; alo_i = lo; rw_i = rw; mx_i = xf;
    be_i   = (be_mode != 1);
    mbus_i = (be_mode == 1) ? ~bank : bank;
    repeat (HALF) @(negedge clk);
    // results of the previous cycle's falling edge
    chk("R4 strobe count", 32'(pulses), 32'(exp_pulses));
    chk("R5 write byte", 32'(wdata_o), 32'(exp_wdata));
    chk("R7 M flag", 32'(m_o), 32'(exp_m));
    pulses = 0;
    if (be_mode != 1) begin
      exp_addr = {bank, lo};
      chk("R2 address in low half", 32'(addr_o), 32'(exp_addr));
    end else begin
      chk("R6 address frozen", 32'(addr_o), 32'(exp_addr));
    end
    phi2_i = 1'b1; mbus_i = data; mx_i = mf;
    be_i   = (be_mode != 2);
    repeat (HALF) @(negedge clk);
    chk("R3 address held in data half", 32'(addr_o), 32'(exp_addr));
    chk("R8 X flag", 32'(x_o), 32'(xf));
    exp_m = mf;
    if (!rw && be_mode == 0) begin
      exp_pulses = 1;
      exp_wdata  = data;
    end else begin
      exp_pulses = 0;   // R5 for reads, R6 for gated cycles
    end
  endtask

  initial begin
    rst = 1'b1; phi2_i = 1'b0; be_i = 1'b1; rw_i = 1'b1; mx_i = 1'b1;
    alo_i = '0; mbus_i = '0;
    repeat (4) @(negedge clk);
    chk("R1 addr", 32'(addr_o), 32'h0);
    chk("R1 wdata", 32'(wdata_o), 32'h0);
    chk("R1 wvalid", 32'(wvalid_o), 32'h0);
    chk("R1 m", 32'(m_o), 32'h1);
    chk("R1 x", 32'(x_o), 32'h1);
    rst = 1'b0;
    for (int i = 0; i <= NCYC; i++) begin
      logic [7:0] ib;
      ib = 8'(i);
      bus_cycle(16'(i * 16'h1357 + 16'h00A5), 8'(i * 29 + 3), 8'(i * 71 + 8'h5C),
                ~ib[0], (i / 2) % 3, ib[3] ^ ib[1], ib[4] ^ ib[0]);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule